// File: doc/BRIEF.md
# LIN Frame Sequencer and Checker

This block tracks LIN bus frames from a stream of events handed to it by an upstream UART receiver. Each event is one of three kinds: a received byte, a break (which carries the byte the receiver assembled while the line was held low), or an idle period on the line. The block walks each frame through its phases: break, sync byte, protected identifier, and a response. It checks the sync value and the two identifier parity bits. When the frame closes, it reports the identifier, the data bytes, their count, the checksum byte and the error flags with a single-cycle strobe. The checksum arithmetic itself belongs to a separate accumulator that consumes these outputs.

A frame closes in one of two ways: on the second idle event in a row, or on the next break. In the break case the zero byte that arrives with the break is thrown away rather than stored. After the identifier, every byte is buffered. When the frame closes, the last buffered byte is taken as the checksum and the earlier ones as data.

Top module: `lin_frame_seq`

## Requirements
- R1: After reset the block waits for a break with `frm_done` low and all frame outputs zero. While waiting, byte and idle events have no effect and produce no strobe.
- R2: A break (event kind 1) moves the block from waiting (or error) to expecting the sync byte. The next byte is taken as sync, and `frm_sync_err` of that frame is 1 exactly when the byte differs from 0x55.
- R3: The byte after sync is the protected identifier. `frm_par_err` is 1 when its bit 6 differs from id0^id1^id2^id4 or its bit 7 differs from NOT(id1^id3^id4^id5), where idN is identifier bit N.
- R4: `frm_pid` reports the whole identifier byte. The 6-bit ID is its bits 5:0.
- R5: Bytes after the identifier are buffered. At close, with n ≥ 1 buffered bytes, `frm_chk` is the n-th byte, `frm_ndata` is n−1, and data byte i (from 0) is in `frm_data[8i+7:8i]`. Unused lanes are zero.
- R6: Idle events (kind 2) are counted while a frame is in progress, and a byte event clears the count. A second consecutive idle closes the frame and returns the block to waiting. A single idle followed by a byte does not close it.
- R7: A break with a zero byte while a frame is in progress closes and reports that frame, then restarts the block at the sync phase without another break.
- R8: A break with a nonzero byte while a frame is in progress discards the frame with no strobe and enters error. In error, bytes and idles are ignored, and only a break leaves it, to the sync phase.
- R9: A frame closed after the identifier with no response bytes reports `frm_no_resp`=1, with `frm_ndata`, `frm_chk` and `frm_data` zero.
- R10: A tenth response byte raises a strobe with `frm_ovf`=1, `frm_ndata`=8 and `frm_chk` equal to the ninth byte. The tenth byte is dropped and the block enters error.
- R11: `frm_done` lasts one cycle. It appears in the cycle after the closing event is accepted. Flags and buffer start clear for every frame.
- R12: A frame closed before its identifier arrives produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | 0 byte, 1 break, 2 idle, 3 ignored |
| ev_byte | input | 8 | Byte value (byte and break events) |
| frm_done | output | 1 | One-cycle frame report strobe |
| frm_pid | output | 8 | Protected identifier byte |
| frm_data | output | 64 | Data bytes, byte i in bits 8i+7:8i |
| frm_ndata | output | 4 | Number of data bytes |
| frm_chk | output | 8 | Checksum byte |
| frm_sync_err | output | 1 | Sync byte was not 0x55 |
| frm_par_err | output | 1 | Identifier parity mismatch |
| frm_no_resp | output | 1 | Header with no response |
| frm_ovf | output | 1 | Response exceeded buffer |

## Verification
The assertions check several properties on every cycle. The strobe is never high in two adjacent cycles, and it only follows an accepted event. The response count never passes the buffer depth. Error can be left only toward the sync phase, and waiting can be left only toward it as well. A report with no response always carries zero count and checksum. The bench scenarios cover the rest: the parity and sync flags for particular identifier values, the split between data and checksum, the effect of idles interleaved with bytes, and the frames that are dropped or reported after a break.

// File: rtl/lin_frame_seq.sv
module lin_frame_seq #(
  parameter int NRESP = 9,
  parameter logic [7:0] SYNC_VAL = 8'h55
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  input  logic [1:0]              ev_kind,
  input  logic [7:0]              ev_byte,
  output logic                    frm_done,
  output logic [7:0]              frm_pid,
  output logic [8*(NRESP-1)-1:0]  frm_data,
  output logic [$clog2(NRESP+1)-1:0] frm_ndata,
  output logic [7:0]              frm_chk,
  output logic                    frm_sync_err,
  output logic                    frm_par_err,
  output logic                    frm_no_resp,
  output logic                    frm_ovf
);
  localparam int ND = NRESP - 1;
  localparam int CW = $clog2(NRESP + 1);

  typedef enum logic [2:0] {S_WAIT, S_SYNC, S_PID, S_DATA, S_ERR} st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic          idl;
  logic [7:0]    pid_q;
  logic          serr_q;
  logic [7:0]    bufr [NRESP];

  wire is_byte = ev_valid && ev_kind == 2'd0;
  wire is_brk  = ev_valid && ev_kind == 2'd1;
  wire is_idle = ev_valid && ev_kind == 2'd2;
  wire active  = st == S_SYNC || st == S_PID || st == S_DATA;
  wire brk_ok  = is_brk && ev_byte == 8'h00;
  wire close_i = active && is_idle && idl;
  wire ovf_hit = st == S_DATA && is_byte && cnt == CW'(NRESP);
  wire emit    = (st == S_DATA && (close_i || brk_ok)) || ovf_hit;

  wire p0 = pid_q[0] ^ pid_q[1] ^ pid_q[2] ^ pid_q[4];
  wire p1 = ~(pid_q[1] ^ pid_q[3] ^ pid_q[4] ^ pid_q[5]);
  wire perr = pid_q[7:6] != {p1, p0};

  logic [8*ND-1:0] dat_c;
  logic [7:0]      chk_c;
  always_comb begin
    for (int i = 0; i < ND; i++)
      dat_c[i*8 +: 8] = (i + 1 < int'(cnt)) ? bufr[i] : 8'h00;
    chk_c = (cnt == '0) ? 8'h00 : bufr[cnt - CW'(1)];
  end

  always_comb begin
    nxt = st;
    case (st)
      S_WAIT: if (is_brk) nxt = S_SYNC;
      S_ERR:  if (is_brk) nxt = S_SYNC;
      default: begin
        if (is_brk)       nxt = brk_ok ? S_SYNC : S_ERR;
        else if (close_i) nxt = S_WAIT;
        else if (is_byte) begin
          if (st == S_SYNC)     nxt = S_PID;
          else if (st == S_PID) nxt = S_DATA;
          else if (ovf_hit)     nxt = S_ERR;
        end
      end
    endcase
  end

  wire clr = nxt == S_WAIT || nxt == S_ERR || (is_brk && nxt == S_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      cnt <= '0;
      idl <= 1'b0;
      pid_q <= '0;
      serr_q <= 1'b0;
      for (int i = 0; i < NRESP; i++) bufr[i] <= '0;
    end else begin
      st <= nxt;
      if (clr) begin
        cnt <= '0;
        idl <= 1'b0;
        pid_q <= '0;
        serr_q <= 1'b0;
        for (int i = 0; i < NRESP; i++) bufr[i] <= '0;
      end else if (active) begin
        if (is_idle) idl <= 1'b1;
        if (is_byte) begin
          idl <= 1'b0;
          if (st == S_SYNC) serr_q <= ev_byte != SYNC_VAL;
          else if (st == S_PID) pid_q <= ev_byte;
          else begin
            bufr[cnt] <= ev_byte;
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_done <= 1'b0;
      frm_pid <= '0;
      frm_data <= '0;
      frm_ndata <= '0;
      frm_chk <= '0;
      frm_sync_err <= 1'b0;
      frm_par_err <= 1'b0;
      frm_no_resp <= 1'b0;
      frm_ovf <= 1'b0;
    end else begin
      frm_done <= emit;
      if (emit) begin
        frm_pid <= pid_q;
        frm_data <= dat_c;
        frm_ndata <= (cnt == '0) ? '0 : cnt - CW'(1);
        frm_chk <= chk_c;
        frm_sync_err <= serr_q;
        frm_par_err <= perr;
        frm_no_resp <= cnt == '0;
        frm_ovf <= ovf_hit;
      end
    end
  end

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);
  assert_done_after_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_done) |-> $past(ev_valid));
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NRESP));
  assert_err_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ERR |=> (st == S_ERR || st == S_SYNC));
  assert_wait_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT |=> (st == S_WAIT || st == S_SYNC));
  assert_noresp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_no_resp) |-> (frm_ndata == '0 && frm_chk == 8'h00));
endmodule

// File: tb/lin_frame_seq_tb.sv
module lin_frame_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int NR = 9;

  logic clk = 1'b0, rst_n = 1'b0, ev_valid = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [7:0] ev_byte = '0;
  logic frm_done, frm_sync_err, frm_par_err, frm_no_resp, frm_ovf;
  logic [7:0] frm_pid, frm_chk;
  logic [63:0] frm_data;
  logic [3:0] frm_ndata;

  lin_frame_seq dut_i (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .frm_done(frm_done), .frm_pid(frm_pid), .frm_data(frm_data),
    .frm_ndata(frm_ndata), .frm_chk(frm_chk), .frm_sync_err(frm_sync_err),
    .frm_par_err(frm_par_err), .frm_no_resp(frm_no_resp), .frm_ovf(frm_ovf));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, stray = 0;
  bit got, finished = 0;
  logic [7:0] rsp [0:9];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
    got = frm_done;
  endtask

  task automatic quiet(input logic [1:0] k, input logic [7:0] b);
    ev(k, b);
    if (got) stray++;
  endtask

  function automatic logic [1:0] par(input logic [7:0] p);
    logic a, c;
    a = p[0] ^ p[1] ^ p[2] ^ p[4];
    c = ~(p[1] ^ p[3] ^ p[4] ^ p[5]);
    return {c, a};
  endfunction

  task automatic expect_frame(input int n, input logic [7:0] sv, input logic [7:0] pid, input bit ovf);
    logic [63:0] ed;
    int nd;
    ed = '0;
    nd = (n == 0) ? 0 : n - 1;
    for (int i = 0; i < nd; i++) ed[i*8 +: 8] = rsp[i];
    check(got, "R5 done strobe", 64'(got), 64'd1);
    check(frm_pid == pid, "R4 pid", 64'(frm_pid), 64'(pid));
    check(frm_data == ed, "R5 data", frm_data, ed);
    check(int'(frm_ndata) == nd, "R5 ndata", 64'(frm_ndata), 64'(nd));
    check(frm_chk == ((n == 0) ? 8'h00 : rsp[n-1]), "R5 chk", 64'(frm_chk), 64'((n == 0) ? 8'h00 : rsp[n-1]));
    check(frm_sync_err == (sv != 8'h55), "R2 sync flag", 64'(frm_sync_err), 64'(sv != 8'h55));
    check(frm_par_err == (pid[7:6] != par(pid)), "R3 parity flag", 64'(frm_par_err), 64'(pid[7:6] != par(pid)));
    check(frm_no_resp == (n == 0), "R9 no response", 64'(frm_no_resp), 64'(n == 0));
    check(frm_ovf == ovf, "R10 overflow flag", 64'(frm_ovf), 64'(ovf));
    @(negedge clk);
    check(!frm_done, "R11 one-cycle strobe", 64'(frm_done), 64'd0);
  endtask

  task automatic header(input logic [7:0] sv, input logic [7:0] pid, input int n, input bit gaps);
    quiet(2'd0, sv);
    quiet(2'd0, pid);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) quiet(2'd2, 8'h00);
      quiet(2'd0, rsp[i]);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] sv, pid;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!frm_done && frm_pid == 0 && frm_data == 0 && frm_ndata == 0, "R1 reset state", 64'(frm_done), 64'd0);
    stray = 0;
    quiet(2'd0, 8'h55); quiet(2'd0, 8'h12); quiet(2'd2, 0); quiet(2'd2, 0); quiet(2'd3, 0);
    check(stray == 0, "R1 ignored while waiting", 64'(stray), 64'd0);

    // R9 header only, closed by idles
    quiet(2'd1, 8'h00);
    stray = 0;
    header(8'h55, 8'h3C, 0, 0);
    quiet(2'd2, 0);
    ev(2'd2, 0);
    expect_frame(0, 8'h55, 8'h3C, 0);
    check(stray == 0, "R9 no early strobe", 64'(stray), 64'd0);

    // R7 break closes frame and restarts at sync
    quiet(2'd1, 8'h00);
    rsp[0] = 8'hA1; rsp[1] = 8'h5E; rsp[2] = 8'h07;
    header(8'h55, 8'h80, 3, 0);
    ev(2'd1, 8'h00);
    expect_frame(3, 8'h55, 8'h80, 0);
    rsp[0] = 8'hC3;
    stray = 0;
    header(8'h55, 8'h11, 1, 0);
    quiet(2'd2, 0);
    ev(2'd2, 0);
    expect_frame(1, 8'h55, 8'h11, 0);
    check(stray == 0, "R7 restart without break", 64'(stray), 64'd0);

    // R6 single idle then byte does not close
    quiet(2'd1, 8'h00);
    stray = 0;
    quiet(2'd0, 8'h55); quiet(2'd0, 8'h42); quiet(2'd2, 0);
    quiet(2'd0, 8'h99); quiet(2'd2, 0); quiet(2'd0, 8'h77);
    check(stray == 0, "R6 single idle no close", 64'(stray), 64'd0);
    rsp[0] = 8'h99; rsp[1] = 8'h77;
    quiet(2'd2, 0);
    ev(2'd2, 0);
    expect_frame(2, 8'h55, 8'h42, 0);
    quiet(2'd0, 8'h01); quiet(2'd2, 0); quiet(2'd2, 0);
    check(stray == 0, "R6 back to waiting", 64'(stray), 64'd0);

    // R8 nonzero break discards and enters error
    quiet(2'd1, 8'h00);
    stray = 0;
    rsp[0] = 8'h10; rsp[1] = 8'h20;
    header(8'h55, 8'h05, 2, 0);
    quiet(2'd1, 8'h3C);
    quiet(2'd0, 8'h55); quiet(2'd0, 8'h05); quiet(2'd0, 8'h01);
    quiet(2'd2, 0); quiet(2'd2, 0);
    check(stray == 0, "R8 discard and ignore in error", 64'(stray), 64'd0);
    quiet(2'd1, 8'h00);
    rsp[0] = 8'hEE; rsp[1] = 8'h0F;
    header(8'h54, 8'hC5, 2, 0);
    ev(2'd1, 8'h00);
    expect_frame(2, 8'h54, 8'hC5, 0);

    // R12 close before identifier
    stray = 0;
    quiet(2'd0, 8'h55); quiet(2'd2, 0); quiet(2'd2, 0);
    quiet(2'd1, 8'h00); quiet(2'd1, 8'h00);
    check(stray == 0, "R12 no strobe without identifier", 64'(stray), 64'd0);

    // R10 overflow
    for (int i = 0; i < 10; i++) rsp[i] = 8'(8'h30 + i);
    header(8'h55, 8'h3D, 9, 0);
    ev(2'd0, rsp[9]);
    expect_frame(9, 8'h55, 8'h3D, 1);
    stray = 0;
    quiet(2'd2, 0); quiet(2'd2, 0); quiet(2'd0, 8'h00);
    check(stray == 0, "R10 error after overflow", 64'(stray), 64'd0);
    quiet(2'd1, 8'h00);
    rsp[0] = 8'hAB;
    header(8'h55, 8'h00, 1, 0);
    quiet(2'd2, 0);
    ev(2'd2, 0);
    expect_frame(1, 8'h55, 8'h00, 0);

    // random frames
    for (int f = 0; f < 60; f++) begin
      sv = ($urandom % 5 == 0) ? 8'($urandom) : 8'h55;
      pid = 8'($urandom);
      n = $urandom % 10;
      for (int i = 0; i < n; i++) rsp[i] = 8'($urandom);
      quiet(2'd1, 8'h00);
      stray = 0;
      header(sv, pid, n, 1);
      if ($urandom % 2) begin
        quiet(2'd2, 0);
        ev(2'd2, 0);
      end else ev(2'd1, 8'h00);
      expect_frame(n, sv, pid, 0);
      check(stray == 0, "R6 no stray strobe", 64'(stray), 64'd0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule